// File: doc/BRIEF.md
# Data Access Address Translation and Permission Checker

This block decides the outcome of one data load or store. It receives the virtual address, the access size, the load/store direction, a bypass flag that requests untranslated (physical) addressing, the current privilege mode, and the result of a translation-buffer lookup done elsewhere. From these it produces either a physical address or a fault code together with a six-bit memory-management status vector that explains the fault.

The checks form a fixed priority chain. Misalignment is tested first. Then come the physical bypass, the canonical-form test, the kernel-only direct-mapped region, the translation miss, and last the per-mode enable masks and the fault-on-read/fault-on-write trap bits of the matching entry. The direct-mapped region skips the translation buffer entirely. Its physical address copies bit 40 of the address into bits 43:40. The response is registered by default, so each request yields one response on the next clock. A parameter can make the path purely combinational instead.

Top module: `dxlate_perm`

## Requirements
- R1: When `va & ((1 << size_log2) - 1)` is nonzero the fault is ALIGN (code 1), even with bypass set or a non-canonical address. Status holds only the write bit (bit 0), and only for stores.
- R2: With an aligned address and `phys_mode` high, the physical address equals the virtual address and the fault is NONE (code 0), whatever the translation inputs are.
- R3: An aligned, translated access whose bits 63:42 are not all equal gets fault PAGE (code 2). Status has bad-address (bit 5) and access-violation (bit 1) set, plus write (bit 0) for stores.
- R4: A canonical address whose bits 47:41 equal 7'h7E is in the direct-mapped region. If the privilege mode is not kernel (0), the fault is ACV (code 3) with access-violation set, plus write for stores.
- R5: A direct-mapped access in kernel mode has no fault and ignores the translation inputs. The physical address is va[39:0], with bits 43:40 all set to va[40] and bits 63:44 zero.
- R6: A translated access with `tlb_hit` low gets fault MISS (code 4), or MISS2 (code 5) when `pte_fetch` is high. Status has the miss bit (bit 4) set, plus write for stores.
- R7: On a hit with permission granted, the physical address is `tlb_ppn` shifted left by 13, OR-ed with va[12:0].
- R8: A store whose bit `priv_mode` of `tlb_wr_en` is clear gets fault PAGE with write and access-violation set, plus fault-on-write (bit 3) if `tlb_fow` is high. A permitted store with `tlb_fow` high gets PAGE with write and fault-on-write set.
- R9: A load whose bit `priv_mode` of `tlb_rd_en` is clear gets fault ACV with access-violation set, plus fault-on-read (bit 2) if `tlb_for` is high. A permitted load with `tlb_for` high gets PAGE with fault-on-read set.
- R10: `rsp_valid` is high exactly one cycle after each `req_valid`. A response with fault NONE carries an all-zero status, and a faulting response carries an all-zero physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| va | input | 64 | Virtual address |
| size_log2 | input | 2 | Access size as log2 of bytes (0..3) |
| is_store | input | 1 | 1 = store, 0 = load |
| phys_mode | input | 1 | Bypass translation, use VA as PA |
| pte_fetch | input | 1 | Request is a page-table-entry fetch |
| priv_mode | input | 2 | Privilege mode, 0 kernel .. 3 user |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_ppn | input | 31 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_for | input | 1 | Entry traps on read |
| tlb_fow | input | 1 | Entry traps on write |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 64 | Physical address (zero on fault) |
| rsp_fault | output | 3 | Fault code 0..5 |
| rsp_status | output | 6 | Status flags |

## Verification
Internal state here is only the response register, so a wrong decision shows at the ports on the response one cycle after the request and nowhere else. A wrong priority order shows as the wrong fault code on an access that breaks two rules at once. For example, a misaligned bypass access must still report ALIGN, and a non-kernel direct-mapped access must report ACV and never a miss. A flag bit in the wrong position shows in the status vector of exactly that response. The directed scenarios therefore pair each fault with the neighbouring rule it must win or lose against.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

   typedef enum logic [2:0] {
      FLT_NONE  = 3'd0,
      FLT_ALIGN = 3'd1,
      FLT_PAGE  = 3'd2,
      FLT_ACV   = 3'd3,
      FLT_MISS  = 3'd4,
      FLT_MISS2 = 3'd5
   } fault_e;

   localparam int ST_W     = 6;
   localparam int ST_WR    = 0;
   localparam int ST_ACV   = 1;
   localparam int ST_FOR   = 2;
   localparam int ST_FOW   = 3;
   localparam int ST_MISS  = 4;
   localparam int ST_BADVA = 5;

   localparam logic [1:0] MODE_KERNEL = 2'd0;

endpackage

// File: rtl/dxl_align.sv
module dxl_align #(
   parameter int VA_W   = 64,
   parameter int SIZE_W = 2
) (
   input  logic [VA_W-1:0]   va,
   input  logic [SIZE_W-1:0] size_log2,
   output logic              misaligned
);
   localparam int MAX_BYTES = 1 << ((1 << SIZE_W) - 1);
   localparam int LOW_W     = $clog2(MAX_BYTES) > 0 ? $clog2(MAX_BYTES) : 1;

   logic [LOW_W-1:0] mask;

   always_comb begin
      mask       = LOW_W'((LOW_W+1)'(1) << size_log2) - LOW_W'(1);
      misaligned = |(va[LOW_W-1:0] & mask);
   end
endmodule

// File: rtl/dxl_region.sv
module dxl_region #(
   parameter int         VA_W      = 64,
   parameter int         PA_W      = 44,
   parameter int         CANON_BIT = 42,
   parameter int         SP_MSB    = 47,
   parameter int         SP_LSB    = 41,
   parameter logic [6:0] SP_TAG    = 7'h7E,
   parameter int         SP_EXT    = 40
) (
   input  logic [VA_W-1:0] va,
   output logic            canonical,
   output logic            superpage,
   output logic [VA_W-1:0] sp_pa
);
   localparam int TOP_W = VA_W - CANON_BIT;
   localparam int TAG_W = SP_MSB - SP_LSB + 1;

   logic [TOP_W-1:0] upper;
   assign upper     = va[VA_W-1:CANON_BIT];
   assign canonical = (&upper) | ~(|upper);
   assign superpage = (va[SP_MSB:SP_LSB] == SP_TAG[TAG_W-1:0]);

   for (genvar b = 0; b < VA_W; b++) begin : g_pa
      if (b < SP_EXT) begin : g_copy
         assign sp_pa[b] = va[b];
      end else if (b < PA_W) begin : g_ext
         assign sp_pa[b] = va[SP_EXT];
      end else begin : g_zero
         assign sp_pa[b] = 1'b0;
      end
   end
endmodule

// File: rtl/dxl_perm.sv
module dxl_perm #(
   parameter int NMODES = 4,
   parameter int MODE_W = 2
) (
   input  logic                   is_store,
   input  logic [MODE_W-1:0]      priv_mode,
   input  logic [NMODES-1:0]      rd_en,
   input  logic [NMODES-1:0]      wr_en,
   input  logic                   trap_rd,
   input  logic                   trap_wr,
   output dxl_pkg::fault_e        fault,
   output logic [dxl_pkg::ST_W-1:0] status
);
   import dxl_pkg::*;

   logic allowed;
   assign allowed = is_store ? wr_en[priv_mode] : rd_en[priv_mode];

   always_comb begin
      fault  = FLT_NONE;
      status = '0;
      if (is_store) begin
         status[ST_WR] = 1'b1;
         if (!allowed) begin
            fault          = FLT_PAGE;
            status[ST_ACV] = 1'b1;
            status[ST_FOW] = trap_wr;
         end else if (trap_wr) begin
            fault          = FLT_PAGE;
            status[ST_FOW] = 1'b1;
         end else begin
            status = '0;
         end
      end else begin
         if (!allowed) begin
            fault          = FLT_ACV;
            status[ST_ACV] = 1'b1;
            status[ST_FOR] = trap_rd;
         end else if (trap_rd) begin
            fault          = FLT_PAGE;
            status[ST_FOR] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dxlate_perm.sv
module dxlate_perm #(
   parameter int VA_W       = 64,
   parameter int PA_W       = 44,
   parameter int PAGE_SHIFT = 13,
   parameter int SIZE_W     = 2,
   parameter int NMODES     = 4,
   parameter int CANON_BIT  = 42,
   parameter int SP_MSB     = 47,
   parameter int SP_LSB     = 41,
   parameter int SP_EXT     = 40,
   parameter bit REG_OUT    = 1'b1,
   localparam int PPN_W     = PA_W - PAGE_SHIFT,
   localparam int MODE_W    = $clog2(NMODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   va,
   input  logic [SIZE_W-1:0] size_log2,
   input  logic              is_store,
   input  logic              phys_mode,
   input  logic              pte_fetch,
   input  logic [MODE_W-1:0] priv_mode,
   input  logic              tlb_hit,
   input  logic [PPN_W-1:0]  tlb_ppn,
   input  logic [NMODES-1:0] tlb_rd_en,
   input  logic [NMODES-1:0] tlb_wr_en,
   input  logic              tlb_for,
   input  logic              tlb_fow,
   output logic              rsp_valid,
   output logic [VA_W-1:0]   rsp_pa,
   output logic [2:0]        rsp_fault,
   output logic [5:0]        rsp_status
);
   import dxl_pkg::*;

   if (PA_W <= SP_EXT || PA_W > VA_W) begin : g_bad_pa
      $error("dxlate_perm: PA_W must lie above SP_EXT and within VA_W");
   end
   if (SP_MSB - SP_LSB + 1 != 7 || SP_MSB >= VA_W) begin : g_bad_sp
      $error("dxlate_perm: direct-map tag must be 7 bits inside VA");
   end
   if (PAGE_SHIFT >= PA_W || CANON_BIT >= VA_W) begin : g_bad_geo
      $error("dxlate_perm: page shift or canonical bit out of range");
   end

   logic            misaligned, canonical, superpage;
   logic [VA_W-1:0] sp_pa;
   fault_e          perm_fault;
   logic [ST_W-1:0] perm_status;

   dxl_align #(.VA_W(VA_W), .SIZE_W(SIZE_W)) u_align (
      .va(va), .size_log2(size_log2), .misaligned(misaligned));

   dxl_region #(.VA_W(VA_W), .PA_W(PA_W), .CANON_BIT(CANON_BIT),
                .SP_MSB(SP_MSB), .SP_LSB(SP_LSB), .SP_TAG(7'h7E),
                .SP_EXT(SP_EXT)) u_region (
      .va(va), .canonical(canonical), .superpage(superpage), .sp_pa(sp_pa));

   dxl_perm #(.NMODES(NMODES), .MODE_W(MODE_W)) u_perm (
      .is_store(is_store), .priv_mode(priv_mode), .rd_en(tlb_rd_en),
      .wr_en(tlb_wr_en), .trap_rd(tlb_for), .trap_wr(tlb_fow),
      .fault(perm_fault), .status(perm_status));

   fault_e          nx_fault;
   logic [ST_W-1:0] nx_status;
   logic [VA_W-1:0] nx_pa;
   logic [VA_W-1:0] hit_pa;

   assign hit_pa = {{(VA_W-PA_W){1'b0}}, tlb_ppn, va[PAGE_SHIFT-1:0]};

   always_comb begin
      nx_fault  = FLT_NONE;
      nx_status = '0;
      nx_pa     = '0;
      if (misaligned) begin
         nx_fault         = FLT_ALIGN;
         nx_status[ST_WR] = is_store;
      end else if (phys_mode) begin
         nx_pa = va;
      end else if (!canonical) begin
         nx_fault            = FLT_PAGE;
         nx_status[ST_WR]    = is_store;
         nx_status[ST_ACV]   = 1'b1;
         nx_status[ST_BADVA] = 1'b1;
      end else if (superpage) begin
         if (priv_mode != MODE_W'(MODE_KERNEL)) begin
            nx_fault          = FLT_ACV;
            nx_status[ST_WR]  = is_store;
            nx_status[ST_ACV] = 1'b1;
         end else begin
            nx_pa = sp_pa;
         end
      end else if (!tlb_hit) begin
         nx_fault           = pte_fetch ? FLT_MISS2 : FLT_MISS;
         nx_status[ST_WR]   = is_store;
         nx_status[ST_MISS] = 1'b1;
      end else begin
         nx_fault  = perm_fault;
         nx_status = perm_status;
         nx_pa     = (perm_fault == FLT_NONE) ? hit_pa : '0;
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_pa     <= '0;
            rsp_fault  <= 3'd0;
            rsp_status <= '0;
         end else begin
            rsp_valid  <= req_valid;
            rsp_pa     <= nx_pa;
            rsp_fault  <= nx_fault;
            rsp_status <= nx_status;
         end
      end
   end else begin : g_comb
      assign rsp_valid  = req_valid;
      assign rsp_pa     = nx_pa;
      assign rsp_fault  = nx_fault;
      assign rsp_status = nx_status;
   end
endmodule

// File: rtl/dxlate_perm_chk.sv
module dxlate_perm_chk #(
   parameter int VA_W    = 64,
   parameter int SIZE_W  = 2,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [VA_W-1:0]   va,
   input logic [SIZE_W-1:0] size_log2,
   input logic              phys_mode,
   input logic              rsp_valid,
   input logic [VA_W-1:0]   rsp_pa,
   input logic [2:0]        rsp_fault,
   input logic [5:0]        rsp_status
);
   logic mis;
   assign mis = |(va[7:0] & (8'((9'(1) << size_log2)) - 8'd1));

   if (REG_OUT) begin : g_seq
      AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid && mis |=> rsp_fault == 3'd1) else $error("align"); // R1
      AST_PHYS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid && !mis && phys_mode |=> rsp_pa == $past(va) && rsp_fault == 3'd0)
         else $error("phys"); // R2
      AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid) else $error("timing"); // R10
      AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> !rsp_valid) else $error("idle"); // R10
   end

   AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault == 3'd0 |-> rsp_status == 6'd0) else $error("clean"); // R10
   AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault != 3'd0 |-> rsp_pa == '0) else $error("pa"); // R10
   AST_MISS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_fault == 3'd4 || rsp_fault == 3'd5) |-> rsp_status[4])
      else $error("miss"); // R6
   AST_BADVA_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status[5] |-> rsp_fault == 3'd2 && rsp_status[1])
      else $error("badva"); // R3
endmodule

bind dxlate_perm dxlate_perm_chk #(.VA_W(VA_W), .SIZE_W(SIZE_W), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(va),
   .size_log2(size_log2), .phys_mode(phys_mode), .rsp_valid(rsp_valid),
   .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_status(rsp_status));

// File: tb/dxlate_perm_bench.sv
`timescale 1ns/1ps
module dxlate_perm_bench;
   localparam int F_NONE = 0, F_ALIGN = 1, F_PAGE = 2, F_ACV = 3, F_MISS = 4, F_MISS2 = 5;
   localparam logic [5:0] S_W = 6'd1, S_ACV = 6'd2, S_FOR = 6'd4, S_FOW = 6'd8,
                          S_MISS = 6'd16, S_BAD = 6'd32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] va = '0;
   logic [1:0]  size_log2 = '0;
   logic        is_store = 1'b0, phys_mode = 1'b0, pte_fetch = 1'b0;
   logic [1:0]  priv_mode = '0;
   logic        tlb_hit = 1'b0;
   logic [30:0] tlb_ppn = '0;
   logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
   logic        tlb_for = 1'b0, tlb_fow = 1'b0;
   logic        rsp_valid;
   logic [63:0] rsp_pa;
   logic [2:0]  rsp_fault;
   logic [5:0]  rsp_status;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   dxlate_perm u_dxlate_perm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(va),
      .size_log2(size_log2), .is_store(is_store), .phys_mode(phys_mode),
      .pte_fetch(pte_fetch), .priv_mode(priv_mode), .tlb_hit(tlb_hit),
      .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
      .tlb_for(tlb_for), .tlb_fow(tlb_fow), .rsp_valid(rsp_valid),
      .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_status(rsp_status));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input logic [63:0] a, input logic [1:0] sz, input logic st,
                         input logic ph, input logic pte, input logic [1:0] md,
                         input logic hit, input logic [30:0] ppn,
                         input logic [3:0] rd, input logic [3:0] wr,
                         input logic fr, input logic fw);
      @(negedge clk);
      va = a; size_log2 = sz; is_store = st; phys_mode = ph; pte_fetch = pte;
      priv_mode = md; tlb_hit = hit; tlb_ppn = ppn; tlb_rd_en = rd; tlb_wr_en = wr;
      tlb_for = fr; tlb_fow = fw; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string tag, input int f, input logic [5:0] s,
                             input logic [63:0] pa);
      check({tag, " valid"}, 64'(rsp_valid), 64'd1);
      check({tag, " fault"}, 64'(rsp_fault), 64'(f));
      check({tag, " status"}, 64'(rsp_status), 64'(s));
      check({tag, " pa"}, rsp_pa, pa);
   endtask

   task automatic t_reset();
      check("R10 reset valid", 64'(rsp_valid), 64'd0);
      check("R10 reset fault", 64'(rsp_fault), 64'd0);
   endtask

   task automatic t_align();
      access(64'h0000_0001_2345_6004, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 31'h5, 4'hF, 4'hF, 1'b0, 1'b0);
      expect_rsp("R1 load 8B", F_ALIGN, 6'd0, 64'd0);
      access(64'h0000_0001_2345_6001, 2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 31'h5, 4'hF, 4'hF, 1'b0, 1'b0);
      expect_rsp("R1 store phys", F_ALIGN, S_W, 64'd0);
      access(64'h0000_0800_0000_0002, 2'd2, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0);
      expect_rsp("R1 over noncanon", F_ALIGN, S_W, 64'd0);
      access(64'h0000_0001_2345_6003, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0);
      expect_rsp("R1 byte ok", F_NONE, 6'd0, 64'h0000_0001_2345_6003);
   endtask

   task automatic t_phys();
      access(64'hDEAD_BEEF_0000_1238, 2'd3, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 31'h0, 4'h0, 4'h0, 1'b1, 1'b1);
      expect_rsp("R2 bypass", F_NONE, 6'd0, 64'hDEAD_BEEF_0000_1238);
   endtask

   task automatic t_noncanon();
      access(64'h0000_0800_0000_0000, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 31'h1, 4'hF, 4'hF, 1'b0, 1'b0);
      expect_rsp("R3 load", F_PAGE, S_BAD | S_ACV, 64'd0);
      access(64'h8000_0000_0000_0000, 2'd2, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 31'h1, 4'hF, 4'hF, 1'b0, 1'b0);
      expect_rsp("R3 store", F_PAGE, S_BAD | S_ACV | S_W, 64'd0);
   endtask

   task automatic t_super();
      access(64'hFFFF_FC12_3456_7890, 2'd3, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0);
      expect_rsp("R4 user load", F_ACV, S_ACV, 64'd0);
      access(64'hFFFF_FC12_3456_7890, 2'd3, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 31'h7, 4'hF, 4'hF, 1'b0, 1'b0);
      expect_rsp("R4 store mode1", F_ACV, S_ACV | S_W, 64'd0);
      access(64'hFFFF_FC12_3456_7890, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b1, 1'b1);
      expect_rsp("R5 bit40 clear", F_NONE, 6'd0, 64'h0000_0012_3456_7890);
      access(64'hFFFF_FD12_3456_7890, 2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b1);
      expect_rsp("R5 bit40 set", F_NONE, 6'd0, 64'h0000_0F12_3456_7890);
   endtask

   task automatic t_miss();
      access(64'h0000_0001_2345_6AB8, 2'd3, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 31'h0, 4'hF, 4'hF, 1'b0, 1'b0);
      expect_rsp("R6 load miss", F_MISS, S_MISS, 64'd0);
      access(64'h0000_0001_2345_6AB8, 2'd3, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 31'h0, 4'hF, 4'hF, 1'b0, 1'b0);
      expect_rsp("R6 store pte miss", F_MISS2, S_MISS | S_W, 64'd0);
   endtask

   task automatic t_hit();
      access(64'h0000_0001_2345_6AB8, 2'd3, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 31'h12345, 4'b1000, 4'b0000, 1'b0, 1'b0);
      expect_rsp("R7 user load hit", F_NONE, 6'd0, (64'h12345 << 13) | 64'h0AB8);
      access(64'h0000_0000_0000_1FFE, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 31'h7FFF_FFFF, 4'b0000, 4'b0001, 1'b0, 1'b0);
      expect_rsp("R7 kernel store top ppn", F_NONE, 6'd0, (64'h7FFF_FFFF << 13) | 64'h1FFE);
   endtask

   task automatic t_store_perm();
      access(64'h0000_0000_0040_0000, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 31'h9, 4'hF, 4'b1011, 1'b0, 1'b0);
      expect_rsp("R8 denied", F_PAGE, S_W | S_ACV, 64'd0);
      access(64'h0000_0000_0040_0000, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 31'h9, 4'hF, 4'b1011, 1'b0, 1'b1);
      expect_rsp("R8 denied fow", F_PAGE, S_W | S_ACV | S_FOW, 64'd0);
      access(64'h0000_0000_0040_0000, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 31'h9, 4'h0, 4'b0100, 1'b1, 1'b1);
      expect_rsp("R8 allowed fow", F_PAGE, S_W | S_FOW, 64'd0);
   endtask

   task automatic t_load_perm();
      access(64'h0000_0000_0040_0010, 2'd3, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 31'h9, 4'b1101, 4'hF, 1'b0, 1'b0);
      expect_rsp("R9 denied", F_ACV, S_ACV, 64'd0);
      access(64'h0000_0000_0040_0010, 2'd3, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 31'h9, 4'b1101, 4'hF, 1'b1, 1'b0);
      expect_rsp("R9 denied for", F_ACV, S_ACV | S_FOR, 64'd0);
      access(64'h0000_0000_0040_0010, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 31'h9, 4'b0001, 4'h0, 1'b1, 1'b1);
      expect_rsp("R9 allowed for", F_PAGE, S_FOR, 64'd0);
   endtask

   task automatic t_timing();
      @(negedge clk);
      check("R10 idle no rsp", 64'(rsp_valid), 64'd0);
   endtask

   initial begin
      #(8.0 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_align();
      t_phys();
      t_noncanon();
      t_super();
      t_miss();
      t_hit();
      t_store_perm();
      t_load_perm();
      t_timing();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule